// File: doc/BRIEF.md
# Eight-Level Prioritising Interrupt Controller

The block collects eight interrupt request lines, latches them into a request register and resolves them against a mask register and an in-service register. It drives a single interrupt output to the host processor. When the host acknowledges, the block returns an 8-bit vector for the winning level and marks that level as in service. Later requests from levels of equal or lower priority are held off until software ends the service.

Software programs the block through a byte-wide register port with chip-select, a one-bit address and write and read strobes. First comes an initialization sequence. After it, operation words set the mask, end service in three ways (highest, named or automatic), move the priority order and pick which register an address-0 read returns. The priority order is kept as a single "lowest level" pointer. Levels rank in circular order starting just above that pointer. By default level 0 is highest.

The vector leaves on a valid-only stream. `vec_valid` is high for exactly one cycle, the cycle after an `ack` cycle, and `vec` must be captured in that cycle. This stream has no ready input, so the host cannot apply back-pressure. `ack` must be a one-cycle pulse per acknowledge. Register reads are combinational. Writes take effect at the clock edge that ends the write cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output and `vec_valid` are low, the mask reads 8'hFF, the in-service register is empty, and requests still latch into the request register while masked.
- R2: An address-0 write with bit 4 set starts initialization. It clears the mask, in-service and request registers, restores default priority, turns automatic end and automatic rotation off, and holds the interrupt output low until the sequence completes. In that word, bit 3 selects level triggering (1) or edge triggering (0). Bit 1 = 0 means one extra address-1 word follows, which is accepted and discarded. Bit 0 = 1 means a final address-1 word follows, whose bit 1 enables automatic end. The first address-1 word after the start is the vector base.
- R3: Once initialized, an address-1 write loads the mask; bit i = 1 blocks level i. An address-1 read returns the mask.
- R4: The interrupt output is high only when some unmasked pending level ranks strictly above every in-service level. Ranks run circularly from the level after the lowest pointer; the default pointer is 7.
- R5: `vec_valid` rises in the cycle after an `ack` cycle with `vec` = {base[7:3], level}. The winning request bit clears and its in-service bit sets. An `ack` with the output low returns level 7 and changes no register.
- R6: Operation word 8'h20 (bits 7..5 = 001, bits 4..3 = 00) clears the highest-ranked in-service bit.
- R7: Operation word 8'h60 | L clears the in-service bit of level L only.
- R8: Operation word 8'hC0 | L makes L the lowest level and L+1 the highest.
- R9: Operation word 8'hA0 clears the highest-ranked in-service bit and makes that level lowest. Operation word 8'hE0 | L clears level L and makes L lowest.
- R10: With automatic end enabled, an acknowledge sets no in-service bit. Operation word 8'h80 enables, and 8'h00 disables, moving each acknowledged level to lowest in that mode.
- R11: In edge mode a request bit sets on a rising input and stays until acknowledged. An input that stays high does not set it again.
- R12: In level mode the request bit follows the input each cycle, so a request that is withdrawn before acknowledge drops the output.
- R13: Address-0 write 8'h0A selects the request register and 8'h0B the in-service register for address-0 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Interrupt request lines, level 0 to 7 |
| cs | input | 1 | Register port select |
| addr | input | 1 | Register address |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| int_out | output | 1 | Interrupt to the processor |
| ack | input | 1 | Acknowledge, one-cycle pulse |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec | output | 8 | Interrupt vector |

## Verification
A request edge driven before a clock edge sets the request register at that edge, so the interrupt output is due one edge later and the bench samples it at the next falling edge. A register write lands at the edge that closes its write cycle, and the bench reads back combinationally half a cycle after that edge. The vector is due one edge after the `ack` cycle, and the bench samples `vec_valid` and `vec` at the falling edge that follows. Expected winners come from a circular first-set search over the pattern, computed in the bench for every request pattern, every mask value and every lowest-level setting.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BASE  = 2'd1,
    ST_LINK  = 2'd2,
    ST_EXTRA = 2'd3
  } init_st_t;

  // decoded operation word, one-cycle pulses
  typedef struct packed {
    logic eoi_ns;
    logic eoi_sp;
    logic rot_ns;
    logic rot_sp;
    logic set_prio;
    logic auto_on;
    logic auto_off;
  } op_cmd_t;

  localparam int unsigned BUS_W = 8;

endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int unsigned LEVELS = 8,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                addr,
  input  logic                wr,
  input  logic [BUS_W-1:0]    wdata,
  output logic                level_mode,
  output logic                aeoi,
  output logic [BUS_W-1:0]    base,
  output logic [LEVELS-1:0]   mask,
  output logic                rd_isr,
  output logic                ready,
  output logic                init_clr,
  output op_cmd_t             cmd,
  output logic [LVL_W-1:0]    cmd_lvl
);

  init_st_t st;
  logic     cascade;
  logic     need_extra;
  logic     wr_en;
  logic     hi_wr;
  logic     op_wr;
  logic     sel_wr;

  assign wr_en    = cs & wr;
  assign init_clr = wr_en & ~addr & wdata[4];
  assign hi_wr    = wr_en & addr;
  assign op_wr    = wr_en & ~addr & ~wdata[4] & ~wdata[3] & (st == ST_READY);
  assign sel_wr   = wr_en & ~addr & ~wdata[4] &  wdata[3] & (st == ST_READY);
  assign ready    = (st == ST_READY);
  assign cmd_lvl  = wdata[LVL_W-1:0];

  always_comb begin
    cmd = '0;
    if (op_wr) begin
      unique case (wdata[7:5])
        3'b001:  cmd.eoi_ns   = 1'b1;
        3'b011:  cmd.eoi_sp   = 1'b1;
        3'b101:  cmd.rot_ns   = 1'b1;
        3'b111:  cmd.rot_sp   = 1'b1;
        3'b110:  cmd.set_prio = 1'b1;
        3'b100:  cmd.auto_on  = 1'b1;
        3'b000:  cmd.auto_off = 1'b1;
        default: cmd = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_READY;
      level_mode <= 1'b0;
      aeoi       <= 1'b0;
      base       <= '0;
      mask       <= '1;
      rd_isr     <= 1'b0;
      cascade    <= 1'b0;
      need_extra <= 1'b0;
    end else if (init_clr) begin
      st         <= ST_BASE;
      level_mode <= wdata[3];
      cascade    <= ~wdata[1];
      need_extra <= wdata[0];
      aeoi       <= 1'b0;
      mask       <= '0;
      rd_isr     <= 1'b0;
    end else begin
      if (hi_wr) begin
        unique case (st)
          ST_BASE: begin
            base <= wdata;
            if (cascade)         st <= ST_LINK;
            else if (need_extra) st <= ST_EXTRA;
            else                 st <= ST_READY;
          end
          ST_LINK:  st <= need_extra ? ST_EXTRA : ST_READY;
          ST_EXTRA: begin
            aeoi <= wdata[1];
            st   <= ST_READY;
          end
          default:  mask <= wdata[LEVELS-1:0];
        endcase
      end
      if (sel_wr && wdata[1]) rd_isr <= wdata[0];
    end
  end

  a_r2_init_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (mask == '0) && !ready);

  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && ready) |=> mask == $past(wdata[LEVELS-1:0]));

endmodule

// File: rtl/irqc_req.sv
module irqc_req #(
  parameter int unsigned LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] irq_in,
  input  logic              level_mode,
  input  logic              clr,
  input  logic [LEVELS-1:0] ack_clr,
  output logic [LEVELS-1:0] irr
);

  logic [LEVELS-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      if (clr)             irr <= '0;
      else if (level_mode) irr <= irq_in & ~ack_clr;
      else                 irr <= (irr & ~ack_clr) | (irq_in & ~prev);
    end
  end

  a_r11_no_relatch_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !clr) |=> ((irr & ~$past(irr) & $past(prev)) == '0));

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int unsigned LEVELS = 8,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] req,
  input  logic [LVL_W-1:0]  top,
  output logic              valid,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  rank
);

  // scan from the lowest rank upward so the highest-ranked hit is kept last
  always_comb begin
    valid = 1'b0;
    level = '0;
    rank  = '0;
    for (int r = LEVELS - 1; r >= 0; r--) begin
      logic [LVL_W-1:0] idx;
      idx = top + LVL_W'(r);
      if (req[idx]) begin
        valid = 1'b1;
        level = idx;
        rank  = LVL_W'(r);
      end
    end
  end

  a_r4_pick_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[level]);

endmodule

// File: rtl/irqc_svc.sv
module irqc_svc
  import irqc_pkg::*;
#(
  parameter int unsigned LEVELS = 8,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              aeoi,
  input  logic              ack_fire,
  input  logic [LVL_W-1:0]  ack_lvl,
  input  op_cmd_t           cmd,
  input  logic [LVL_W-1:0]  cmd_lvl,
  input  logic              top_valid,
  input  logic [LVL_W-1:0]  top_lvl,
  output logic [LEVELS-1:0] isr,
  output logic [LVL_W-1:0]  low
);

  logic              auto_rot;
  logic [LEVELS-1:0] isr_n;
  logic [LVL_W-1:0]  low_n;
  logic              auto_n;

  always_comb begin
    isr_n  = isr;
    low_n  = low;
    auto_n = auto_rot;
    if (ack_fire) begin
      if (!aeoi)         isr_n[ack_lvl] = 1'b1;
      else if (auto_rot) low_n = ack_lvl;
    end
    if ((cmd.eoi_ns || cmd.rot_ns) && top_valid) begin
      isr_n[top_lvl] = 1'b0;
      if (cmd.rot_ns) low_n = top_lvl;
    end
    if (cmd.eoi_sp || cmd.rot_sp) begin
      isr_n[cmd_lvl] = 1'b0;
      if (cmd.rot_sp) low_n = cmd_lvl;
    end
    if (cmd.set_prio) low_n  = cmd_lvl;
    if (cmd.auto_on)  auto_n = 1'b1;
    if (cmd.auto_off) auto_n = 1'b0;
    if (clr) begin
      isr_n  = '0;
      low_n  = '1;
      auto_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr      <= '0;
      low      <= '1;
      auto_rot <= 1'b0;
    end else begin
      isr      <= isr_n;
      low      <= low_n;
      auto_rot <= auto_n;
    end
  end

  a_r5_one_new_service: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $countones(isr & ~$past(isr)) <= 1);

  a_r10_auto_end_sets_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && ack_fire && !clr) |=> (isr & ~$past(isr)) == '0);

  a_r6_top_service_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.eoi_ns && top_valid && !clr) |=> !isr[$past(top_lvl)]);

  a_r8_lowest_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.set_prio && !clr && !ack_fire) |=> low == $past(cmd_lvl));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned LEVELS = 8,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] irq_in,
  input  logic              cs,
  input  logic              addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              int_out,
  input  logic              ack,
  output logic              vec_valid,
  output logic [BUS_W-1:0]  vec
);

  logic              level_mode;
  logic              aeoi;
  logic [BUS_W-1:0]  base;
  logic [LEVELS-1:0] mask;
  logic              rd_isr;
  logic              ready;
  logic              init_clr;
  op_cmd_t           cmd;
  logic [LVL_W-1:0]  cmd_lvl;
  logic [LEVELS-1:0] irr;
  logic [LEVELS-1:0] isr;
  logic [LVL_W-1:0]  low;
  logic [LVL_W-1:0]  top;
  logic              pend_valid;
  logic [LVL_W-1:0]  pend_lvl;
  logic [LVL_W-1:0]  pend_rank;
  logic              svc_valid;
  logic [LVL_W-1:0]  svc_lvl;
  logic [LVL_W-1:0]  svc_rank;
  logic              ack_fire;
  logic [LEVELS-1:0] ack_clr;
  logic [BUS_W-1:0]  mask_b;
  logic [BUS_W-1:0]  irr_b;
  logic [BUS_W-1:0]  isr_b;

  irqc_cfg #(.LEVELS(LEVELS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .wdata(wdata),
    .level_mode(level_mode), .aeoi(aeoi), .base(base), .mask(mask),
    .rd_isr(rd_isr), .ready(ready), .init_clr(init_clr), .cmd(cmd), .cmd_lvl(cmd_lvl)
  );

  irqc_req #(.LEVELS(LEVELS)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .clr(init_clr), .ack_clr(ack_clr), .irr(irr)
  );

  assign top = low + LVL_W'(1);

  irqc_pick #(.LEVELS(LEVELS)) u_pick_req (
    .clk(clk), .rst_n(rst_n), .req(irr & ~mask), .top(top),
    .valid(pend_valid), .level(pend_lvl), .rank(pend_rank)
  );

  irqc_pick #(.LEVELS(LEVELS)) u_pick_svc (
    .clk(clk), .rst_n(rst_n), .req(isr), .top(top),
    .valid(svc_valid), .level(svc_lvl), .rank(svc_rank)
  );

  irqc_svc #(.LEVELS(LEVELS)) u_svc (
    .clk(clk), .rst_n(rst_n), .clr(init_clr), .aeoi(aeoi),
    .ack_fire(ack_fire), .ack_lvl(pend_lvl), .cmd(cmd), .cmd_lvl(cmd_lvl),
    .top_valid(svc_valid), .top_lvl(svc_lvl), .isr(isr), .low(low)
  );

  assign int_out  = ready && pend_valid && (!svc_valid || (pend_rank < svc_rank));
  assign ack_fire = ack && int_out;
  assign ack_clr  = ack_fire ? (LEVELS'(1) << pend_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= ack;
      if (ack) vec <= {base[BUS_W-1:LVL_W], (ack_fire ? pend_lvl : {LVL_W{1'b1}})};
    end
  end

  always_comb begin
    mask_b = '0;
    irr_b  = '0;
    isr_b  = '0;
    mask_b[LEVELS-1:0] = mask;
    irr_b[LEVELS-1:0]  = irr;
    isr_b[LEVELS-1:0]  = isr;
    if (!(cs && rd))  rdata = '0;
    else if (addr)    rdata = mask_b;
    else if (rd_isr)  rdata = isr_b;
    else              rdata = irr_b;
  end

  a_r5_vector_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  a_r5_no_vector_unasked: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  a_r4_int_needs_open_request: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~mask) != '0);

endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cs = 1'b0, addr = 1'b0, wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec;
  logic       int_out, vec_valid;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .int_out(int_out), .ack(ack),
    .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rreg(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata; cs = 0; rd = 0;
  endtask

  task automatic get_isr(output logic [7:0] d);
    wreg(0, 8'h0B); rreg(0, d);
  endtask

  task automatic get_irr(output logic [7:0] d);
    wreg(0, 8'h0A); rreg(0, d);
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    n_chk++;
    if (vec_valid !== 1'b1) begin
      n_bad++; $display("FAIL R5 vec_valid actual=%b expected=1", vec_valid);
    end
    v = vec;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); irq = p;
    @(negedge clk); irq = '0;
  endtask

  task automatic init(input logic [7:0] w1, input logic [7:0] b, input logic [7:0] w4);
    wreg(0, w1); wreg(1, b);
    if (w1[0]) wreg(1, w4);
  endtask

  // first set level in circular order from level top
  function automatic int first_from(input logic [7:0] p, input int top);
    for (int r = 0; r < 8; r++) if (p[(top + r) % 8]) return (top + r) % 8;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v;
    int w, expw;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 int", {7'd0, int_out}, 8'h00);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    rreg(1, d); chk("R1 mask", d, 8'hFF);
    pulse(8'hFF);
    chk("R1 masked int", {7'd0, int_out}, 8'h00);
    get_irr(d); chk("R1 irr latches", d, 8'hFF);
    get_isr(d); chk("R1 isr", d, 8'h00);

    // R2 cascade path with discarded word, int held during init
    wreg(0, 8'h10);
    pulse(8'h01);
    chk("R2 int held in init", {7'd0, int_out}, 8'h00);
    wreg(1, 8'h80); wreg(1, 8'h55);
    rreg(1, d); chk("R2 extra word discarded", d, 8'h00);
    wreg(1, 8'hF0);
    rreg(1, d); chk("R3 mask readback", d, 8'hF0);
    pulse(8'h01); do_ack(v); chk("R2 base from second word", v, 8'h80);

    // R4 R5 R6 nested sweep over all request patterns
    for (int p = 1; p < 256; p++) begin
      init(8'h13, 8'h40, 8'h00);
      pulse(8'(p));
      chk("R4 int raised", {7'd0, int_out}, 8'h01);
      w = first_from(8'(p), 0);
      do_ack(v); chk("R5 vector", v, 8'h40 | 8'(w));
      chk("R4 lower blocked", {7'd0, int_out}, 8'h00);
      get_isr(d); chk("R5 isr set", d, 8'h01 << w);
      wreg(0, 8'h20);
      get_isr(d); chk("R6 eoi clears", d, 8'h00);
      chk("R4 rest pending", {7'd0, int_out}, {7'd0, ((8'(p) & ~(8'h01 << w)) != 0)});
    end

    // R3 mask sweep
    for (int m = 0; m < 256; m++) begin
      init(8'h13, 8'h40, 8'h00);
      wreg(1, 8'(m));
      rreg(1, d); chk("R3 mask read", d, 8'(m));
      pulse(8'hFF);
      chk("R3 masked int", {7'd0, int_out}, {7'd0, (m != 255)});
      if (m != 255) begin
        w = first_from(~8'(m), 0);
        do_ack(v); chk("R3 unmasked winner", v, 8'h40 | 8'(w));
      end
    end

    // R8 specific rotation for every lowest level
    for (int l = 0; l < 8; l++) begin
      init(8'h13, 8'h40, 8'h00);
      wreg(0, 8'hC0 | 8'(l));
      pulse(8'hFF);
      do_ack(v); chk("R8 top after lowest", v, 8'h40 | 8'((l + 1) % 8));
      chk("R8 others below service", {7'd0, int_out}, 8'h00);
    end

    // R4 R6 R7 nesting and both clears
    init(8'h13, 8'h40, 8'h00);
    pulse(8'h08); do_ack(v); chk("R5 level3", v, 8'h43);
    pulse(8'h20); chk("R4 lower held", {7'd0, int_out}, 8'h00);
    pulse(8'h02); chk("R4 higher nests", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R4 nested vector", v, 8'h41);
    get_isr(d); chk("R4 two in service", d, 8'h0A);
    wreg(0, 8'h20);
    get_isr(d); chk("R6 highest cleared", d, 8'h08);
    chk("R4 still held", {7'd0, int_out}, 8'h00);
    wreg(0, 8'h63);
    get_isr(d); chk("R7 named cleared", d, 8'h00);
    do_ack(v); chk("R4 pending released", v, 8'h45);
    init(8'h13, 8'h40, 8'h00);
    pulse(8'h08); do_ack(v);
    pulse(8'h02); do_ack(v);
    wreg(0, 8'h63);
    get_isr(d); chk("R7 only level3", d, 8'h02);

    // R9 rotate on end
    init(8'h13, 8'h40, 8'h00);
    pulse(8'h04); do_ack(v);
    wreg(0, 8'hA0);
    get_isr(d); chk("R9 cleared", d, 8'h00);
    pulse(8'h0C);
    expw = first_from(8'h0C, 3);
    do_ack(v); chk("R9 rotated winner", v, 8'h40 | 8'(expw));
    wreg(0, 8'hE3);
    get_isr(d); chk("R9 specific cleared", d, 8'h00);
    pulse(8'h08);
    expw = first_from(8'h0C, 4);
    do_ack(v); chk("R9 specific rotated", v, 8'h40 | 8'(expw));

    // R10 automatic end with automatic rotation
    init(8'h13, 8'h40, 8'h02);
    wreg(0, 8'h80);
    pulse(8'h03);
    do_ack(v); chk("R10 first", v, 8'h40);
    get_isr(d); chk("R10 isr empty", d, 8'h00);
    chk("R10 next raised", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R10 second", v, 8'h41);
    pulse(8'h03);
    expw = first_from(8'h03, 2);
    do_ack(v); chk("R10 rotated order", v, 8'h40 | 8'(expw));
    wreg(0, 8'h00);
    pulse(8'h01);
    expw = first_from(8'h03, 1);
    do_ack(v); chk("R10 rotation held", v, 8'h40 | 8'(expw));
    do_ack(v); chk("R10 no move", v, 8'h40);
    pulse(8'h03);
    do_ack(v); chk("R10 order fixed", v, 8'h41);

    // R11 edge behaviour
    init(8'h13, 8'h40, 8'h00);
    @(negedge clk); irq = 8'h10;
    @(negedge clk);
    chk("R11 edge latched", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R11 vector", v, 8'h44);
    wreg(0, 8'h20);
    chk("R11 held high no relatch", {7'd0, int_out}, 8'h00);
    get_irr(d); chk("R11 irr empty", d, 8'h00);
    @(negedge clk); irq = 8'h00;
    @(negedge clk); irq = 8'h10;
    @(negedge clk);
    chk("R11 new edge", {7'd0, int_out}, 8'h01);
    irq = 8'h00;

    // R12 level behaviour
    init(8'h1B, 8'h40, 8'h00);
    @(negedge clk); irq = 8'h10;
    @(negedge clk);
    chk("R12 level raised", {7'd0, int_out}, 8'h01);
    irq = 8'h00;
    @(negedge clk); @(negedge clk);
    chk("R12 withdrawn", {7'd0, int_out}, 8'h00);
    get_irr(d); chk("R12 irr follows", d, 8'h00);
    @(negedge clk); irq = 8'h10;
    @(negedge clk);
    do_ack(v); chk("R12 vector", v, 8'h44);
    chk("R12 in service", {7'd0, int_out}, 8'h00);
    wreg(0, 8'h20);
    chk("R12 still high reasserts", {7'd0, int_out}, 8'h01);
    irq = 8'h00;

    // R5 spurious acknowledge, R13 read select
    init(8'h13, 8'h40, 8'h00);
    @(negedge clk);
    do_ack(v); chk("R5 spurious vector", v, 8'h47);
    get_isr(d); chk("R5 spurious no service", d, 8'h00);
    pulse(8'h81);
    get_irr(d); chk("R13 irr selected", d, 8'h81);
    do_ack(v);
    get_isr(d); chk("R13 isr selected", d, 8'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule